// File: doc/BRIEF.md
# Receive Status Latch with Masked Interrupt

This block collects the alarm and event indications of a bit-error-rate test receiver into one byte-wide status register that a host can poll, and raises an active-low interrupt when any enabled status bit is set. The receive path drives it with three single-cycle event pulses: a bit error was seen, the bit counter wrapped, and the error counter wrapped. It also drives three condition levels: the receiver is hunting for pattern lock, the line is all ones, and the line is all zeros. A live lock indication passes straight through to the register without being held.

Each held bit keeps a short-lived indication visible until software has seen it. Reading the status register clears the event bits outright. A condition bit is cleared by a read only if its condition has ended by then. A separate mask register chooses which held bits may pull the interrupt low. Register access uses a simple strobe port: read data is valid in the same cycle as the read strobe, and side effects take place on the clock edge that ends that cycle.

Top module: `bert_status_irq`

## Requirements
- R1: With `rd_en` high and `addr` equal to `STATUS_ADDR` (default 0x14), `rdata` shows the status byte in the same cycle. Bit 6 is all-ones, bit 5 is all-zeros, bit 4 is lock-hunt, bit 3 is bit-error, bit 2 is bit-counter wrap, bit 1 is error-counter wrap, and bit 0 is live lock.
- R2: A held status bit (bits 6 to 1) becomes 1 on the clock edge at which its input is high. It stays 1 on every later edge until a status read clears it.
- R3: The event bits (3, 2, 1) are 0 after the edge that ends a status read, when their event input is low in that cycle.
- R4: At the edge that ends a status read, a condition bit (6, 5, 4) whose condition input is still high stays 1. One whose input is low clears to 0.
- R5: An event or condition input that is high in the same cycle as a status read wins over the clear, so its bit is 1 after that edge.
- R6: Status bit 0 equals `sync_live` in the same cycle and is never held.
- R7: The mask register at `MASK_ADDR` (default 0x15) is written from `wdata[6:0]` when `wr_en` is high, and reads back on `rdata[6:0]`. Bit 7 of both the mask and the status register reads 0, and a written mask bit 7 is not stored.
- R8: `irq_n` is 0 exactly when some held bit in 6 to 1 is 1 and its mask bit is 1. The change shows in the same cycle as the register change. Mask bit 0 and the live lock bit have no effect on `irq_n` with the default `SYNC_IRQ = 0`.
- R9: A write to `STATUS_ADDR` changes nothing. A read of any address other than the two registers returns 0. A read of the mask register does not clear status bits.
- R10: A synchronous active-high `rst` clears every held status bit and every mask bit, leaving `irq_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while `rd_en` is high |
| ev_bit_err | input | 1 | Pulse: bit error detected |
| ev_bitcnt_ovf | input | 1 | Pulse: bit counter wrapped |
| ev_errcnt_ovf | input | 1 | Pulse: error counter wrapped |
| cond_los | input | 1 | Level: receiver hunting for lock |
| cond_all_ones | input | 1 | Level: all-ones pattern on the line |
| cond_all_zeros | input | 1 | Level: all-zeros pattern on the line |
| sync_live | input | 1 | Level: live lock state |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The properties assume that the event inputs are single-cycle pulses and that the condition inputs are steady between clock edges. They also assume that `addr` is stable for the whole cycle in which a strobe is high. The directed tasks change every input only on the falling clock edge, and they raise a strobe for exactly one cycle with its address held. Same-cycle collisions of an event with a status read are driven on purpose, because the set-over-clear priority is a property the checker relies on.

// File: rtl/stat_pkg.sv
package stat_pkg;
   // Bit positions inside the status byte. The host decodes these, so they are fixed.
   localparam int unsigned BIT_SYNC  = 0;
   localparam int unsigned BIT_ECOV  = 1;
   localparam int unsigned BIT_BCOV  = 2;
   localparam int unsigned BIT_BERR  = 3;
   localparam int unsigned BIT_LOS   = 4;
   localparam int unsigned BIT_AZERO = 5;
   localparam int unsigned BIT_AONE  = 6;
   localparam int unsigned BIT_SPARE = 7;

   // Held bits occupy positions 1..6 of the byte.
   localparam int unsigned LAT_N    = 6;
   localparam int unsigned LAT_BASE = 1;
   localparam int unsigned MASK_N   = 7;

   function automatic int unsigned lat_idx(input int unsigned byte_pos);
      return byte_pos - LAT_BASE;
   endfunction
endpackage

// File: rtl/stat_flag_bank.sv
module stat_flag_bank #(
   parameter int unsigned NUM = 6
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NUM-1:0] set_i,
   input  logic           clr_i,
   output logic [NUM-1:0] q_o
);
   // Each cell sets when its input is high and clears on a read strobe.
   // The set input wins, so a condition that is still present survives the read.
   for (genvar k = 0; k < NUM; k++) begin : g_cell
      logic q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= 1'b0;
         else if (set_i[k])
            q <= 1'b1;
         else if (clr_i)
            q <= 1'b0;
      end
      assign q_o[k] = q;
   end
endmodule

// File: rtl/stat_mask_reg.sv
module stat_mask_reg #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q;

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (we_i)
         q <= d_i;
   end

   assign q_o = q;
endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen #(
   parameter int unsigned LAT_N    = 6,
   parameter bit          SYNC_IRQ = 1'b0
) (
   input  logic [LAT_N-1:0] lat_i,
   input  logic [LAT_N-1:0] lat_en_i,
   input  logic             sync_i,
   input  logic             sync_en_i,
   output logic             irq_n_o
);
   logic lat_any;
   assign lat_any = |(lat_i & lat_en_i);

   if (SYNC_IRQ) begin : g_with_sync
      assign irq_n_o = ~(lat_any | (sync_i & sync_en_i));
   end else begin : g_held_only
      logic unused_sync;
      assign unused_sync = sync_i ^ sync_en_i;
      assign irq_n_o = ~lat_any;
   end
endmodule

// File: rtl/stat_regif.sv
module stat_regif #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h14,
   parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'h15
) (
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              status_clr_o,
   output logic              mask_we_o
);
   logic hit_status;
   logic hit_mask;

   assign hit_status   = (addr_i == STATUS_ADDR);
   assign hit_mask     = (addr_i == MASK_ADDR);
   assign status_clr_o = rd_en_i & hit_status;
   assign mask_we_o    = wr_en_i & hit_mask;

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         if (hit_status)
            rdata_o = status_i;
         else if (hit_mask)
            rdata_o = mask_i;
      end
   end
endmodule

// File: rtl/bert_status_irq.sv
module bert_status_irq
   import stat_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h14,
   parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'h15,
   parameter bit          SYNC_IRQ    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ev_bit_err,
   input  logic              ev_bitcnt_ovf,
   input  logic              ev_errcnt_ovf,
   input  logic              cond_los,
   input  logic              cond_all_ones,
   input  logic              cond_all_zeros,
   input  logic              sync_live,
   output logic              irq_n
);
   localparam int unsigned PAD_W = DATA_W - 8;

   if (DATA_W < 8) begin : g_chk_width
      $error("bert_status_irq: DATA_W must be at least 8");
   end
   if (STATUS_ADDR == MASK_ADDR) begin : g_chk_addr
      $error("bert_status_irq: status and mask addresses must differ");
   end

   logic [LAT_N-1:0]  lat_set;
   logic [LAT_N-1:0]  lat_q;
   logic [MASK_N-1:0] mask_q;
   logic              status_clr;
   logic              mask_we;
   logic [DATA_W-1:0] status_byte;
   logic [DATA_W-1:0] mask_byte;

   always_comb begin
      lat_set = '0;
      lat_set[lat_idx(BIT_ECOV)]  = ev_errcnt_ovf;
      lat_set[lat_idx(BIT_BCOV)]  = ev_bitcnt_ovf;
      lat_set[lat_idx(BIT_BERR)]  = ev_bit_err;
      lat_set[lat_idx(BIT_LOS)]   = cond_los;
      lat_set[lat_idx(BIT_AZERO)] = cond_all_zeros;
      lat_set[lat_idx(BIT_AONE)]  = cond_all_ones;
   end

   stat_flag_bank #(.NUM(LAT_N)) u_flags (
      .clk   (clk),
      .rst   (rst),
      .set_i (lat_set),
      .clr_i (status_clr),
      .q_o   (lat_q)
   );

   stat_mask_reg #(.WIDTH(MASK_N)) u_mask (
      .clk  (clk),
      .rst  (rst),
      .we_i (mask_we),
      .d_i  (wdata[MASK_N-1:0]),
      .q_o  (mask_q)
   );

   always_comb begin
      status_byte                        = '0;
      status_byte[BIT_SYNC]              = sync_live;
      status_byte[BIT_AONE:BIT_ECOV]     = lat_q;
      mask_byte                          = '0;
      mask_byte[MASK_N-1:0]              = mask_q;
   end

   stat_regif #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .STATUS_ADDR (STATUS_ADDR),
      .MASK_ADDR   (MASK_ADDR)
   ) u_regif (
      .rd_en_i      (rd_en),
      .wr_en_i      (wr_en),
      .addr_i       (addr),
      .status_i     (status_byte),
      .mask_i       (mask_byte),
      .rdata_o      (rdata),
      .status_clr_o (status_clr),
      .mask_we_o    (mask_we)
   );

   stat_irq_gen #(.LAT_N(LAT_N), .SYNC_IRQ(SYNC_IRQ)) u_irq (
      .lat_i     (lat_q),
      .lat_en_i  (mask_q[BIT_AONE:BIT_ECOV]),
      .sync_i    (sync_live),
      .sync_en_i (mask_q[BIT_SYNC]),
      .irq_n_o   (irq_n)
   );

   logic unused_wdata;
   assign unused_wdata = ^{wdata[DATA_W-1:MASK_N], PAD_W[0]};
endmodule

// File: rtl/stat_checker.sv
module stat_checker
   import stat_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h14,
   parameter bit          SYNC_IRQ    = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic              ev_bit_err,
   input logic              cond_los,
   input logic              sync_live,
   input logic [LAT_N-1:0]  lat_q,
   input logic [MASK_N-1:0] mask_q,
   input logic              irq_n
);
   localparam int unsigned I_BERR = BIT_BERR - LAT_BASE;
   localparam int unsigned I_LOS  = BIT_LOS - LAT_BASE;

   logic rd_stat;
   logic en_any;
   assign rd_stat = rd_en && (addr == STATUS_ADDR);
   assign en_any  = |(lat_q & mask_q[BIT_AONE:BIT_ECOV]);

   p_sync_live_r6: assert property (@(posedge clk) disable iff (rst)
      rd_stat |-> (rdata[BIT_SYNC] == sync_live));

   p_spare_zero_r7: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> !rdata[BIT_SPARE]);

   p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
      ev_bit_err |=> lat_q[I_BERR]);

   p_event_holds_r2: assert property (@(posedge clk) disable iff (rst)
      (lat_q[I_BERR] && !rd_stat) |=> lat_q[I_BERR]);

   p_event_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (rd_stat && !ev_bit_err) |=> !lat_q[I_BERR]);

   p_cond_keeps_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_stat && cond_los) |=> lat_q[I_LOS]);

   p_cond_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_stat && !cond_los) |=> !lat_q[I_LOS]);

   p_irq_low_r8: assert property (@(posedge clk) disable iff (rst)
      en_any |-> !irq_n);

   if (!SYNC_IRQ) begin : g_irq_high
      p_irq_high_r8: assert property (@(posedge clk) disable iff (rst)
         !en_any |-> irq_n);
   end
endmodule

bind bert_status_irq stat_checker #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .STATUS_ADDR (STATUS_ADDR),
   .SYNC_IRQ    (SYNC_IRQ)
) u_stat_checker (
   .clk        (clk),
   .rst        (rst),
   .rd_en      (rd_en),
   .addr       (addr),
   .rdata      (rdata),
   .ev_bit_err (ev_bit_err),
   .cond_los   (cond_los),
   .sync_live  (sync_live),
   .lat_q      (lat_q),
   .mask_q     (mask_q),
   .irq_n      (irq_n)
);

// File: tb/test_bert_status_irq.sv
`timescale 1ns/1ps
module test_bert_status_irq;
   localparam logic [7:0] A_STAT = 8'h14;
   localparam logic [7:0] A_MASK = 8'h15;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic [7:0] rdata;
   logic       ev_bit_err = 1'b0, ev_bitcnt_ovf = 1'b0, ev_errcnt_ovf = 1'b0;
   logic       cond_los = 1'b0, cond_all_ones = 1'b0, cond_all_zeros = 1'b0;
   logic       sync_live = 1'b0;
   logic       irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bert_status_irq i_bert_status_irq (
      .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ev_bit_err(ev_bit_err),
      .ev_bitcnt_ovf(ev_bitcnt_ovf), .ev_errcnt_ovf(ev_errcnt_ovf),
      .cond_los(cond_los), .cond_all_ones(cond_all_ones),
      .cond_all_zeros(cond_all_zeros), .sync_live(sync_live), .irq_n(irq_n)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   // Read: strobe for one cycle, sample before the edge that applies side effects.
   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0; addr = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ev_errcnt_ovf = 1'b1;
         1: ev_bitcnt_ovf = 1'b1;
         2: ev_bit_err = 1'b1;
         3: cond_los = 1'b1;
         4: cond_all_zeros = 1'b1;
         default: cond_all_ones = 1'b1;
      endcase
      @(negedge clk);
      {ev_errcnt_ovf, ev_bitcnt_ovf, ev_bit_err} = '0;
      {cond_los, cond_all_zeros, cond_all_ones} = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A_STAT, d); check("R10 status after reset", d, 8'h00);
      rd(A_MASK, d); check("R10 mask after reset", d, 8'h00);
      #1 check("R10 irq_n after reset", {7'b0, irq_n}, 8'h01);
   endtask

   task automatic t_layout();
      logic [7:0] d;
      for (int k = 0; k < 6; k++) begin
         pulse(k);
         rd(A_STAT, d); check("R1 R2 bit position", d, 8'h02 << k);
         rd(A_STAT, d); check("R3 R4 cleared after read", d, 8'h00);
      end
   endtask

   task automatic t_hold();
      logic [7:0] d;
      pulse(2);
      repeat (5) @(negedge clk);
      rd(A_STAT, d); check("R2 held bit", d, 8'h08);
      rd(A_STAT, d); check("R3 event cleared", d, 8'h00);
   endtask

   task automatic t_cond();
      logic [7:0] d;
      @(negedge clk); cond_los = 1'b1;
      rd(A_STAT, d); check("R4 los read", d, 8'h10);
      rd(A_STAT, d); check("R4 los kept while present", d, 8'h10);
      @(negedge clk); cond_los = 1'b0;
      rd(A_STAT, d); check("R4 los held after end", d, 8'h10);
      rd(A_STAT, d); check("R4 los cleared", d, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      @(negedge clk);
      rd_en = 1'b1; addr = A_STAT; ev_bit_err = 1'b1;
      #1 d = rdata;
      check("R5 read before set", d, 8'h00);
      @(negedge clk);
      rd_en = 1'b0; addr = '0; ev_bit_err = 1'b0;
      rd(A_STAT, d); check("R5 set wins over clear", d, 8'h08);
      rd(A_STAT, d); check("R5 then clears", d, 8'h00);
   endtask

   task automatic t_sync();
      logic [7:0] d;
      @(negedge clk); sync_live = 1'b1;
      rd(A_STAT, d); check("R6 sync live", d, 8'h01);
      rd(A_STAT, d); check("R6 sync stays live", d, 8'h01);
      @(negedge clk); sync_live = 1'b0;
      rd(A_STAT, d); check("R6 sync not held", d, 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(A_MASK, 8'hFF);
      rd(A_MASK, d); check("R7 mask bit7 dropped", d, 8'h7F);
      wr(A_MASK, 8'h00);
      wr(A_STAT, 8'hFF);
      rd(A_STAT, d); check("R9 status write ignored", d, 8'h00);
      pulse(2);
      rd(8'h20, d); check("R9 other address reads 0", d, 8'h00);
      rd(A_MASK, d); check("R9 mask read", d, 8'h00);
      rd(A_STAT, d); check("R9 mask read did not clear", d, 8'h08);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(A_MASK, 8'h00);
      pulse(2);
      #1 check("R8 masked source no irq", {7'b0, irq_n}, 8'h01);
      wr(A_MASK, 8'h08);
      #1 check("R8 enabled source irq", {7'b0, irq_n}, 8'h00);
      rd(A_STAT, d);
      #1 check("R8 irq released after clear", {7'b0, irq_n}, 8'h01);
      wr(A_MASK, 8'h01);
      @(negedge clk); sync_live = 1'b1;
      #1 check("R8 sync mask no effect", {7'b0, irq_n}, 8'h01);
      @(negedge clk); sync_live = 1'b0;
      wr(A_MASK, 8'h10);
      pulse(3);
      #1 check("R8 los irq", {7'b0, irq_n}, 8'h00);
      rd(A_STAT, d);
   endtask

   task automatic t_midreset();
      logic [7:0] d;
      wr(A_MASK, 8'h7E);
      pulse(5); pulse(1);
      do_reset();
      rd(A_STAT, d); check("R10 status cleared", d, 8'h00);
      rd(A_MASK, d); check("R10 mask cleared", d, 8'h00);
      #1 check("R10 irq_n idle", {7'b0, irq_n}, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_layout();
      t_hold();
      t_cond();
      t_collide();
      t_sync();
      t_regs();
      t_irq();
      t_midreset();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule